// File: doc/BRIEF.md
# Embedded Program/Erase Operation Engine

This block models the internal algorithm engine of a byte-wide flash array. A command decoder in front of it has already recognised a complete bus command sequence and hands over a single request: program one byte, erase the whole array, add a sector to a pending sector erase, or abort. The engine then holds the array busy for a number of clock cycles set by parameters, and applies the change to a small internal byte array when the operation completes.

While an operation is pending or running, a read does not return array contents. It returns a status byte. That byte carries a data-poll bit, a bit that flips on every read, a timeout bit, and a bit that shows whether the sector-erase collection window is still open. Sector erase requests are collected for a window of cycles, and each new one restarts the window, so several sectors are erased as one batch. When an operation finishes, the engine drops back to plain array reads on its own. A per-sector protection mask keeps chosen sectors unchanged by both program and erase.

Top module: `flash_op_engine`

## Requirements
- R1: During and after reset, `busy` is 0, `rd_data` is 0, the toggle state is cleared, and every array byte holds 0xFF.
- R2: A program request (`req_op`=0) to an unprotected sector whose data only clears bits (no 1 where the stored byte has a 0) raises `busy` for exactly PROG_CYC cycles. Afterwards the byte reads back as the old value AND the data.
- R3: A read while programming returns a status byte. Bit 7 is the inverse of bit 7 of the data being written. Bits 5, 4 and 3 are 0. Bits 2..0 equal bits 2..0 of the data being written.
- R4: While `busy` is high, status bit 6 reads 0 on the first read of the operation and flips on each later read.
- R5: A program request whose data has a 1 where the stored byte has a 0 holds `busy` for FAIL_CYC cycles and then sets status bit 5. `busy` then stays high until an abort request (`req_op`=3), and the array is not changed.
- R6: A sector erase request (`req_op`=2, sector = top SECT_W address bits) opens a collection window of WIN_CYC cycles. During the window, status bits 7, 5, 3 and 2..0 are 0. The erase then runs for ERASE_CYC cycles with status bit 3 at 1 and bit 7 at 0.
- R7: A further sector erase request inside the window adds its sector and restarts the full WIN_CYC window.
- R8: Any other request inside the window cancels the batch. `busy` is 0 on the next cycle and the array is unchanged.
- R9: Requests that arrive while an erase is running are ignored. The erase ends on schedule and the array shows no effect of the ignored request.
- R10: A chip erase request (`req_op`=1) raises `busy` for ERASE_CYC cycles. Every unprotected sector then reads 0xFF.
- R11: A program request to a sector whose `prot_mask` bit is 1 is ignored (`busy` stays 0). An erase leaves protected sectors unchanged.
- R12: When `busy` is 0, a read returns the addressed array byte in the cycle after `rd_en`, and successive reads stop toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe from the command decoder |
| req_op | input | 2 | 0 program, 1 chip erase, 2 sector erase, 3 abort |
| req_addr | input | ADDR_W | Byte address; top SECT_W bits select the sector |
| req_data | input | 8 | Byte to program |
| prot_mask | input | 2**SECT_W | Per-sector protection, 1 = protected |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte or status byte, registered |
| busy | output | 1 | An operation is pending, running or failed |

## Verification
Every result is registered, so a read presented on one edge shows in `rd_data` just after that edge, and a request taken on edge E0 makes `busy` visible after E0. The bench drives and samples at the falling edge. It counts the rising edges after each request, including those used by reads, so that the fall of `busy` lands after exactly PROG_CYC, FAIL_CYC, WIN_CYC+ERASE_CYC or ERASE_CYC edges. Status reads are placed on known edges: the first read after a restart is timed to land in the first erase cycle, and timeout reads come after FAIL_CYC edges.

// File: rtl/flash_eng_pkg.sv
// Package: shared types for the program/erase engine.
// Assumes an 8-bit data path; the status byte layout depends on it.
package flash_eng_pkg;
    localparam int BYTE_W = 8;

    // Request codes handed over by the command decoder.
    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_CHIP  = 2'b01,
        OP_SECT  = 2'b10,
        OP_ABORT = 2'b11
    } op_e;

    // Engine phases; anything but PH_READ counts as busy.
    typedef enum logic [2:0] {
        PH_READ,
        PH_PROG,
        PH_FAIL,
        PH_WIN,
        PH_ERASE
    } phase_e;
endpackage

// File: rtl/fe_array.sv
// Module: fe_array
// Byte array with one read port, one lookup port, a byte write and a
// per-sector erase. Resets to the erased value (all ones).
// Assumes the write and the erase are never both asked for in one cycle.
module fe_array
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_W-1:0]    rd_byte,
    input  logic [ADDR_W-1:0]    look_addr,
    output logic [BYTE_W-1:0]    look_byte,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 er_en,
    input  logic [(1<<SECT_W)-1:0] er_mask
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Sector index of an array slot.
    function automatic logic [SECT_W-1:0] sect_of(input int idx);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(idx);
        return a[ADDR_W-1 -: SECT_W];
    endfunction

    // Array update: reset to erased, then sector erase or byte write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (er_en && er_mask[sect_of(i)])
                mem[i] <= '1;
            else if (wr_en && wr_addr == ADDR_W'(i))
                mem[i] <= wr_data;
        end
    end

    // Combinational read and lookup ports.
    assign rd_byte   = mem[rd_addr];
    assign look_byte = mem[look_addr];

    // R9/R10: a write never coincides with an erase.
    assert_no_wr_er_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && er_en));
endmodule

// File: rtl/fe_seq.sv
// Module: fe_seq
// Operation sequencer. Takes one request at a time while idle and runs
// program, chip erase, or windowed sector erase on cycle counters.
// Assumes requests are single-cycle strobes and that FAIL_CYC > 0.
module fe_seq
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 8,
    parameter int FAIL_CYC  = 20,
    parameter int WIN_CYC   = 16,
    parameter int ERASE_CYC = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [BYTE_W-1:0]      req_data,
    input  logic [(1<<SECT_W)-1:0] prot_mask,
    input  logic [BYTE_W-1:0]      look_byte,
    output phase_e                 phase,
    output logic                   poll_bit,
    output logic [2:0]             low_bits,
    output logic                   wr_en,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [BYTE_W-1:0]      wr_data,
    output logic                   er_en,
    output logic [(1<<SECT_W)-1:0] er_mask
);
    localparam int NSECT   = 1 << SECT_W;
    localparam int MAX_A   = (PROG_CYC > FAIL_CYC) ? PROG_CYC : FAIL_CYC;
    localparam int MAX_B   = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
    localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] FAIL_LAST  = CNT_W'(FAIL_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);

    op_e                op;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  tgt_addr;
    logic [BYTE_W-1:0]  tgt_data;
    logic               bad;
    logic [NSECT-1:0]   sel;
    logic [SECT_W-1:0]  req_sect;
    logic [NSECT-1:0]   req_onehot;
    logic [CNT_W-1:0]   prog_last;

    // Request decode: op code, target sector and its one-hot form.
    assign op         = op_e'(req_op);
    assign req_sect   = req_addr[ADDR_W-1 -: SECT_W];
    assign req_onehot = NSECT'(1) << req_sect;
    assign prog_last  = bad ? FAIL_LAST : PROG_LAST;

    // Phase machine with a shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_READ;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
            bad      <= 1'b0;
            sel      <= '0;
        end else begin
            case (phase)
                PH_READ: begin
                    if (req_valid) begin
                        cnt <= '0;
                        case (op)
                            OP_PROG: begin
                                if (!prot_mask[req_sect]) begin
                                    phase    <= PH_PROG;
                                    tgt_addr <= req_addr;
                                    tgt_data <= req_data;
                                    bad      <= |(req_data & ~look_byte);
                                end
                            end
                            OP_CHIP: begin
                                phase <= PH_ERASE;
                                sel   <= '1;
                            end
                            OP_SECT: begin
                                phase <= PH_WIN;
                                sel   <= req_onehot;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_PROG: begin
                    if (cnt == prog_last)
                        phase <= bad ? PH_FAIL : PH_READ;
                    else
                        cnt <= cnt + 1'b1;
                end
                PH_FAIL: begin
                    if (req_valid && op == OP_ABORT)
                        phase <= PH_READ;
                end
                PH_WIN: begin
                    if (req_valid) begin
                        if (op == OP_SECT) begin
                            sel <= sel | req_onehot;
                            cnt <= '0;
                        end else begin
                            phase <= PH_READ;
                            sel   <= '0;
                        end
                    end else if (cnt == WIN_LAST) begin
                        phase <= PH_ERASE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ERASE: begin
                    if (cnt == ERASE_LAST) begin
                        phase <= PH_READ;
                        sel   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_READ;
            endcase
        end
    end

    // Array commands issued in the last cycle of an operation.
    assign wr_en    = (phase == PH_PROG) && (cnt == PROG_LAST) && !bad;
    assign wr_addr  = tgt_addr;
    assign wr_data  = tgt_data;
    assign er_en    = (phase == PH_ERASE) && (cnt == ERASE_LAST);
    assign er_mask  = sel & ~prot_mask;

    // Status fields taken from the byte being programmed.
    assign poll_bit = ~tgt_data[BYTE_W-1];
    assign low_bits = tgt_data[2:0];

    // R11: a program aimed at a protected sector leaves the engine idle.
    assert_prot_prog_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && req_valid && op == OP_PROG && prot_mask[req_sect])
        |=> phase == PH_READ);

    // R7: a sector erase inside the window keeps the window and restarts it.
    assert_window_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WIN && req_valid && op == OP_SECT)
        |=> (phase == PH_WIN && cnt == '0));

    // R8: any other request inside the window cancels the batch.
    assert_window_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WIN && req_valid && op != OP_SECT)
        |=> (phase == PH_READ && sel == '0));

    // R9: a running erase is not cut short by any request.
    assert_erase_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ERASE && cnt != ERASE_LAST) |=> phase == PH_ERASE);

    // R5: a failed program stays failed until an abort arrives.
    assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FAIL && !(req_valid && op == OP_ABORT)) |=> phase == PH_FAIL);
endmodule

// File: rtl/fe_status.sv
// Module: fe_status
// Read path. Returns the array byte when idle, or a composed status byte
// while busy, and keeps the toggle bit that flips on each busy read.
// Assumes the array read port is combinational.
module fe_status
    import flash_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              poll_bit,
    input  logic [2:0]        low_bits,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] arr_byte,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy
);
    logic              tog;
    logic [BYTE_W-1:0] status;

    assign busy = (phase != PH_READ);

    // Status byte: {poll, toggle, timeout, 0, window/erase, low three}.
    always_comb begin
        case (phase)
            PH_PROG:  status = {poll_bit, tog, 1'b0, 1'b0, 1'b0, low_bits};
            PH_FAIL:  status = {poll_bit, tog, 1'b1, 1'b0, 1'b0, low_bits};
            PH_WIN:   status = {1'b0,     tog, 1'b0, 1'b0, 1'b0, 3'b000};
            PH_ERASE: status = {1'b0,     tog, 1'b0, 1'b0, 1'b1, 3'b000};
            default:  status = arr_byte;
        endcase
    end

    // Read register and toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            tog     <= 1'b0;
        end else begin
            if (rd_en)
                rd_data <= busy ? status : arr_byte;
            if (!busy)
                tog <= 1'b0;
            else if (rd_en)
                tog <= ~tog;
        end
    end

    // R4: each busy read flips the toggle bit.
    assert_toggle_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> tog != $past(tog));

    // R12: an idle read returns the array byte one cycle later.
    assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_en) |=> rd_data == $past(arr_byte));

    // R6: a read during a running erase shows bit 3 set and bit 7 clear.
    assert_erase_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ERASE && rd_en) |=> (rd_data[3] && !rd_data[7]));

    // R3: a read while programming shows bit 3 clear.
    assert_prog_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROG && rd_en) |=> !rd_data[3]);
endmodule

// File: rtl/flash_op_engine.sv
// Module: flash_op_engine (top)
// Embedded program/erase engine: sequencer, byte array and read path.
// Assumes requests come one cycle wide from a command decoder.
module flash_op_engine
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 8,
    parameter int FAIL_CYC  = 20,
    parameter int WIN_CYC   = 16,
    parameter int ERASE_CYC = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [7:0]             req_data,
    input  logic [(1<<SECT_W)-1:0] prot_mask,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_data,
    output logic                   busy
);
    localparam int NSECT = 1 << SECT_W;

    phase_e            phase;
    logic              poll_bit;
    logic [2:0]        low_bits;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic              er_en;
    logic [NSECT-1:0]  er_mask;
    logic [BYTE_W-1:0] arr_byte;
    logic [BYTE_W-1:0] look_byte;

    fe_seq #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
        .FAIL_CYC(FAIL_CYC), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .prot_mask(prot_mask),
        .look_byte(look_byte), .phase(phase), .poll_bit(poll_bit),
        .low_bits(low_bits), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .er_en(er_en), .er_mask(er_mask)
    );

    fe_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_byte(arr_byte),
        .look_addr(req_addr), .look_byte(look_byte), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .er_en(er_en), .er_mask(er_mask)
    );

    fe_status u_status (
        .clk(clk), .rst_n(rst_n), .phase(phase), .poll_bit(poll_bit),
        .low_bits(low_bits), .rd_en(rd_en), .arr_byte(arr_byte),
        .rd_data(rd_data), .busy(busy)
    );

    // R2: busy rises only after an accepted request.
    assert_busy_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/flash_op_engine_tb.sv
module flash_op_engine_tb;
    localparam int PROG_CYC  = 8;
    localparam int FAIL_CYC  = 20;
    localparam int WIN_CYC   = 16;
    localparam int ERASE_CYC = 24;
    localparam logic [1:0] C_PROG = 2'd0, C_CHIP = 2'd1, C_SECT = 2'd2, C_ABORT = 2'd3;

    // Program vectors: {address[13:8], data[7:0]}; each only clears bits.
    localparam logic [13:0] PVEC [0:7] = '{
        14'h005A, 14'h01C3, 14'h130F, 14'h2580,
        14'h3E77, 14'h05F0, 14'h0530, 14'h2A00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic [3:0] prot_mask = '0;
    logic       rd_en = 1'b0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] model [64];

    always #10 clk = ~clk;

    flash_op_engine #(
        .ADDR_W(6), .SECT_W(2), .PROG_CYC(PROG_CYC), .FAIL_CYC(FAIL_CYC),
        .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .prot_mask(prot_mask),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        tick();
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic settle(input int start, output int n);
        n = start;
        while (busy && n < 1000) begin
            tick();
            n++;
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got hang expected completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        for (int i = 0; i < 64; i++) model[i] = 8'hFF;

        // R1: reset state.
        repeat (3) tick();
        check("R1 busy in reset", busy, 0);
        check("R1 rd_data in reset", rd_data, 8'h00);
        rst_n = 1'b1;
        tick();
        check("R1 busy after reset", busy, 0);
        rd(6'h00, v); check("R1 erased byte", v, 8'hFF);
        rd(6'h3F, v); check("R1 erased last byte", v, 8'hFF);

        // R2, R3, R4: table of program vectors.
        for (int k = 0; k < 8; k++) begin
            logic [5:0] a;
            logic [7:0] d;
            logic [7:0] st;
            a = PVEC[k][13:8];
            d = PVEC[k][7:0];
            st = {~d[7], 1'b0, 3'b000, d[2:0]};
            send(C_PROG, a, d);
            check("R2 busy after program request", busy, 1);
            rd(a, v); check("R3 program status first read", v, st);
            rd(a, v); check("R4 toggle on second read", v, st | 8'h40);
            settle(2, n); check("R2 program busy cycles", n, PROG_CYC);
            model[a] = model[a] & d;
            rd(a, v); check("R2 programmed value", v, model[a]);
        end

        // R12: idle reads do not toggle.
        rd(6'h01, v); check("R12 idle read one", v, 8'hC3);
        rd(6'h01, v); check("R12 idle read two", v, 8'hC3);

        // R5: program that tries to set a cleared bit (0x30 -> 0x31).
        send(C_PROG, 6'h05, 8'h31);
        rd(6'h05, v); check("R5 status before timeout", v, 8'h81);
        repeat (FAIL_CYC - 1) tick();
        rd(6'h05, v); check("R5 timeout bit after FAIL_CYC", v, 8'hE1);
        check("R5 busy held after timeout", busy, 1);
        repeat (5) tick();
        check("R5 busy still held", busy, 1);
        send(C_ABORT, 6'h00, 8'h00);
        check("R5 abort releases", busy, 0);
        rd(6'h05, v); check("R5 array unchanged", v, 8'h30);

        // R8: window cancelled by another request (a program here).
        send(C_SECT, 6'h00, 8'h00);
        rd(6'h00, v); check("R6 window status first", v, 8'h00);
        rd(6'h00, v); check("R6 window status toggled", v, 8'h40);
        send(C_PROG, 6'h10, 8'h00);
        check("R8 busy drops after cancel", busy, 0);
        rd(6'h00, v); check("R8 sector kept", v, 8'h5A);
        rd(6'h10, v); check("R8 program in window not applied", v, 8'hFF);

        // R6, R7: two sectors batched with a window restart.
        send(C_SECT, 6'h13, 8'h00);
        repeat (6) tick();
        send(C_SECT, 6'h25, 8'h00);
        repeat (WIN_CYC) tick();
        rd(6'h00, v); check("R6 erase running status", v, 8'h08);
        settle(WIN_CYC + 1, n);
        check("R7 busy cycles from restart", n, WIN_CYC + ERASE_CYC);
        rd(6'h13, v); check("R7 first sector erased", v, 8'hFF);
        rd(6'h25, v); check("R7 added sector erased", v, 8'hFF);
        rd(6'h2A, v); check("R7 added sector erased 2", v, 8'hFF);
        rd(6'h00, v); check("R6 other sector kept", v, 8'h5A);
        rd(6'h3E, v); check("R6 last sector kept", v, 8'h77);

        // R11: protected program is ignored.
        prot_mask = 4'b1000;
        send(C_PROG, 6'h3E, 8'h00);
        check("R11 protected program no busy", busy, 0);
        rd(6'h3E, v); check("R11 protected byte kept", v, 8'h77);

        // R9, R10: chip erase with a request during the erase.
        send(C_CHIP, 6'h00, 8'h00);
        repeat (3) tick();
        send(C_PROG, 6'h00, 8'h00);
        settle(4, n); check("R10 chip erase busy cycles", n, ERASE_CYC);
        rd(6'h00, v); check("R9 ignored program had no effect", v, 8'hFF);
        rd(6'h05, v); check("R10 sector zero erased", v, 8'hFF);
        rd(6'h01, v); check("R10 byte erased", v, 8'hFF);
        rd(6'h3E, v); check("R11 protected sector survives erase", v, 8'h77);
        rd(6'h3E, v); check("R12 no toggle after completion", v, 8'h77);

        report();
        $finish;
    end
endmodule